// File: doc/BRIEF.md
# Split-Mode Programmable Delay Line

This block delays a byte stream by a programmable number of clock cycles. The byte is carried as two 4-bit lanes, and each lane has its own tap selector on a shared chain structure. A 4-bit length code sets the delay to code + 3 cycles, which gives a range of 3 to 18. That count includes the input register and the output register.

A mode bit chooses between two arrangements:
- In equal mode, both lanes follow the length code.
- In split mode, the upper lane is pinned at the longest delay of 18 cycles, while the lower lane still follows the code.

Typical uses are aligning pixel or sample streams and building mixed-delay paths, such as holding a side field back further than the main field.

The length code and the mode bit are registered on the same edge as the data. A setting captured at one edge first steers the output register at the following edge. If the length is changed while data streams, samples are repeated or dropped at the output. The data itself is never corrupted.

Top module: `split_delay_line`

## Requirements
- R1: With the registered length code c, the lower lane (bits 3:0) of the output word produced at an edge equals the lower lane of the input captured c + 3 - 1 edges earlier, so that the total delay is c + 3 cycles (code 0 gives 3, code 15 gives 18), in either mode.
- R2: With the mode bit low (equal mode), the upper lane (bits 7:4) has the same c + 3 cycle delay as the lower lane.
- R3: With the mode bit high (split mode), the upper lane is delayed by exactly 18 cycles whatever the length code is, and the lower lane keeps following R1.
- R4: A length or mode value presented before edge k is captured at edge k. The output word produced at edge k still uses the previous setting, and the new setting first selects the word produced at edge k+1.
- R5: Raising the code by one while a stream is flowing makes exactly one output word appear twice in a row.
- R6: Lowering the code by one while a stream is flowing skips exactly one input word at the output, and the neighbouring words are unaffected.
- R7: While the active-low synchronous reset is low, the output is zero. Reset clears every data and control register, and the cleared controls mean equal mode with a 3-cycle delay. After release, the words that leave the pipeline before new data reaches the output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | Data word; bits 7:4 upper lane, bits 3:0 lower lane |
| len_sel | input | 4 | Length code; delay = code + 3 cycles |
| split_en | input | 1 | 0 = equal mode, 1 = split mode (upper lane fixed at 18) |
| dout | output | 8 | Delayed data word |

## Verification
The hardest situation to reach from the ports is a control change in the middle of a stream. At that point, the output word is chosen by a setting captured one edge earlier and by data captured up to 18 edges earlier, so a bench can misjudge by one cycle in either direction.

To reach it, the stimulus sweeps every code in both modes with held settings. It then steps the code up and down by one over a counting data pattern, so that a repeat or a skip is visible as a numeric step. It ends with thousands of cycles of random data in which the code and the mode change at random points. Each output word is checked per lane against an input history kept in the bench.

// File: rtl/dl_pkg.sv
// Package dl_pkg
// Shared types for the split-mode delay line.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package dl_pkg;
    typedef enum logic {
        MODE_EQUAL = 1'b0,
        MODE_SPLIT = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/dl_ctrl_reg.sv
// Module dl_ctrl_reg
// Registers the length code and the mode bit on the data edge, and turns the
// registered setting into one tap index per lane (lower and top lane).
// Assumes: tap index i gives a total delay of i + 2 cycles (input register
// plus output register), so code c maps to index c + 1 and the top lane in
// split mode maps to the last tap.
module dl_ctrl_reg #(
    parameter int CODE_W = 4,
    parameter int NTAPS  = 2 ** CODE_W,
    parameter int IDX_W  = $clog2(NTAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] len_sel,
    input  logic              split_en,
    output logic [IDX_W-1:0]  idx_lo,
    output logic [IDX_W-1:0]  idx_hi
);
    import dl_pkg::*;

    logic [CODE_W-1:0] code_q;
    lane_mode_e        mode_q;

    // Capture the controls alongside the data; cleared to equal mode, code 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mode_q <= MODE_EQUAL;
        end else begin
            code_q <= len_sel;
            mode_q <= lane_mode_e'(split_en);
        end
    end

    // Map the registered setting to tap indices for the two lane classes.
    always_comb begin
        idx_lo = IDX_W'(code_q) + IDX_W'(1);
        idx_hi = (mode_q == MODE_SPLIT) ? IDX_W'(NTAPS) : idx_lo;
    end
endmodule

// File: rtl/dl_lane.sv
// Module dl_lane
// One lane of the delay line: an input register, a chain of NTAPS further
// stages, a one-of-NTAPS selector on taps 1..NTAPS and an output register.
// Assumes: idx stays in 1..NTAPS (supplied by dl_ctrl_reg); any other
// value yields zero.
module dl_lane #(
    parameter int LANE_W = 4,
    parameter int NTAPS  = 16,
    parameter int IDX_W  = $clog2(NTAPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] d,
    input  logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] q
);
    logic [LANE_W-1:0] tap [NTAPS+1];
    logic [LANE_W-1:0] picked;

    // Input register (tap 0) and the shifting chain behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= NTAPS; i++) tap[i] <= '0;
        end else begin
            tap[0] <= d;
            for (int i = 1; i <= NTAPS; i++) tap[i] <= tap[i-1];
        end
    end

    // Selector ahead of the output register.
    always_comb begin
        picked = '0;
        for (int i = 1; i <= NTAPS; i++) begin
            if (idx == IDX_W'(i)) picked = tap[i];
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= picked;
    end
endmodule

// File: rtl/split_delay_line.sv
// Module split_delay_line
// Top of the programmable delay line. Splits the word into LANES lanes of
// LANE_W bits; the top lane follows idx_hi (pinned to the longest delay in
// split mode), every other lane follows idx_lo.
// Assumes: DATA_W is a multiple of LANE_W; one clock, synchronous reset.
module split_delay_line #(
    parameter int DATA_W = 8,
    parameter int LANE_W = 4,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_sel,
    input  logic              split_en,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int NTAPS = 2 ** CODE_W;
    localparam int IDX_W = $clog2(NTAPS + 1);

    logic [IDX_W-1:0] idx_lo;
    logic [IDX_W-1:0] idx_hi;
    logic [IDX_W-1:0] lane_idx [LANES];

    dl_ctrl_reg #(.CODE_W(CODE_W), .NTAPS(NTAPS), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_sel  (len_sel),
        .split_en (split_en),
        .idx_lo   (idx_lo),
        .idx_hi   (idx_hi)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit IS_TOP = (g == LANES - 1);
        assign lane_idx[g] = IS_TOP ? idx_hi : idx_lo;

        dl_lane #(.LANE_W(LANE_W), .NTAPS(NTAPS), .IDX_W(IDX_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (din[g*LANE_W +: LANE_W]),
            .idx   (lane_idx[g]),
            .q     (dout[g*LANE_W +: LANE_W])
        );
    end

    // ---------------- assertions ----------------
    logic [4:0] since_rst;

    // Count edges since reset release (saturating) so history checks stay valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 5'd31) since_rst <= since_rst + 5'd1;
    end

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (dout == '0));

    if (CODE_W == 4 && LANE_W == 4 && DATA_W == 8) begin : g_chk
        // R1
        min_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 5'd4 && $past(idx_lo) == 5'd1)
            |-> (dout[3:0] == $past(din[3:0], 3)));

        // R2
        equal_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 5'd20 && $past(idx_lo) == 5'd16 && $past(idx_hi) == 5'd16)
            |-> (dout == $past(din, 18)));

        // R3
        upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 5'd20 && $past(idx_hi) == 5'd16)
            |-> (dout[7:4] == $past(din[7:4], 18)));
    end
endmodule

// File: tb/split_delay_line_bench.sv
module split_delay_line_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] din;
    logic [3:0] len_sel;
    logic       split_en;
    logic [7:0] dout;

    int n_vec  = 0;
    int n_fail = 0;

    split_delay_line u_split_delay_line (
        .clk(clk), .rst_n(rst_n), .din(din),
        .len_sel(len_sel), .split_en(split_en), .dout(dout)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference model state
    int       edge_n   = -1;
    int       last_rst = -1000;
    bit [7:0] hist [64];
    int       q_code = 0, q_mode = 0, pq_code = 0, pq_mode = 0;
    bit [7:0] exp_w;
    bit       in_rst;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp_v, edge_n);
        end
    endtask

    function automatic bit [3:0] lane_at(int d, bit top);
        int idx;
        idx = edge_n - d + 1;
        if (idx < 0 || idx <= last_rst) return 4'h0;
        return top ? hist[idx % 64][7:4] : hist[idx % 64][3:0];
    endfunction

    // One clock edge: update model, then compare per lane away from the edge.
    task automatic tick();
        int d_lo, d_hi;
        @(posedge clk);
        edge_n++;
        pq_code = q_code; pq_mode = q_mode;
        in_rst  = !rst_n;
        if (in_rst) begin
            q_code = 0; q_mode = 0; last_rst = edge_n;
        end else begin
            q_code = len_sel; q_mode = split_en;
        end
        hist[edge_n % 64] = din;
        d_lo = pq_code + 3;
        d_hi = pq_mode ? 18 : d_lo;
        if (in_rst) exp_w = 8'h00;
        else        exp_w = {lane_at(d_hi, 1'b1), lane_at(d_lo, 1'b0)};
        @(negedge clk);
        if (in_rst) begin
            check("R7", dout, 8'h00);
        end else begin
            check("R1", {4'h0, dout[3:0]}, {4'h0, exp_w[3:0]});
            check(pq_mode ? "R3" : "R2", {4'h0, dout[7:4]}, {4'h0, exp_w[7:4]});
        end
    endtask

    task automatic run_rand(int cycles);
        for (int i = 0; i < cycles; i++) begin
            din = 8'($urandom);
            tick();
        end
    endtask

    logic [7:0] cnt;
    logic [7:0] o_prev, o_0, o_1;

    task automatic count_tick();
        din = cnt; cnt = cnt + 8'd1;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; din = 8'hA5; len_sel = 4'd9; split_en = 1'b1;
        @(negedge clk);
        // R7: output stays zero while reset is held, with busy inputs
        run_rand(6);
        rst_n = 1'b1;

        // R1/R2/R3: sweep every code in both modes with held settings
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                split_en = m[0]; len_sel = 4'(c);
                run_rand(24);
            end
        end

        // R7: reset in mid-stream, zeros flush out afterwards
        len_sel = 4'd15; split_en = 1'b0;
        run_rand(10);
        rst_n = 1'b0; run_rand(3); rst_n = 1'b1;
        run_rand(25);

        // R4/R5: raise code 2 -> 3 under a counting stream
        split_en = 1'b0; len_sel = 4'd2; cnt = 8'd0;
        for (int i = 0; i < 25; i++) count_tick();
        o_prev = dout;
        len_sel = 4'd3; count_tick(); o_0 = dout;
        count_tick(); o_1 = dout;
        check("R4", o_0, o_prev + 8'd1);
        check("R5", o_1, o_0);
        for (int i = 0; i < 25; i++) count_tick();

        // R4/R6: lower code 3 -> 2 under a counting stream
        o_prev = dout;
        len_sel = 4'd2; count_tick(); o_0 = dout;
        count_tick(); o_1 = dout;
        check("R4", o_0, o_prev + 8'd1);
        check("R6", o_1, o_0 + 8'd2);
        count_tick();
        check("R6", dout, o_1 + 8'd1);

        // R1/R2/R3/R4: random data with random mid-stream control changes
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) len_sel  = 4'($urandom);
            if ($urandom_range(0, 9) == 0) split_en = 1'($urandom);
            din = 8'($urandom);
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule